// File: doc/BRIEF.md
# Fractional-N Divide Controller

This block produces the integer division value that a fractional-N feedback divider uses on each of its cycles. Over many cycles the average of those values is INT + FRAC/MOD. Each time the reference-rate strobe `step` is asserted, a cascade of three modulo-MOD accumulators advances by one update. The carries of the three stages are combined into a small signed correction, and the registered output becomes `n_out = INT + correction`. The cascade shapes the quantisation noise to third order.

Software loads two registers through a simple write port. The ratio register holds INT and FRAC. The modulus register holds MOD. The modulus is double buffered: a written value waits in a pending slot and only becomes active on the next ratio-register write. That ratio write also clears every accumulator and the carry history, so a new setting always starts from a known phase.

The following settings are required for correct operation: 2 ≤ MOD, FRAC < MOD, and INT ≥ 3 whenever FRAC is non-zero.

Top module: `fracn_divctl`

## Requirements
- R1: After reset, `n_out` is 0, INT and FRAC are 0, and both the active and the pending modulus equal `RST_MOD` (default 4095). With these values, every strobe yields 0.
- R2: A write with `wr_sel`=0 loads INT from `wr_data[20:12]` and FRAC from `wr_data[11:0]`. It clears all three accumulators and the carry history. `n_out` keeps its old value until the next accepted strobe.
- R3: A write with `wr_sel`=1 stores `wr_data[11:0]` as the pending modulus. The output sequence keeps using the previously active modulus.
- R4: A write with `wr_sel`=0 copies the pending modulus into the active modulus in the same cycle that it loads INT and FRAC.
- R5: `n_out` changes only on the clock edge after a cycle with `step`=1 and `wr_en`=0. A strobe that arrives in the same cycle as any write is dropped.
- R6: Every output value lies in the range INT−3 to INT+4.
- R7: With FRAC=0, every accepted strobe yields exactly INT.
- R8: On an accepted strobe, the stages update in order. Stage 1 adds FRAC to its residue. Stage 2 adds stage 1's new residue. Stage 3 adds stage 2's new residue. A stage whose sum reaches MOD subtracts MOD and sets its carry c1, c2 or c3. The output is INT + c1 + (c2 − c2') + (c3 − 2·c3' + c3''), where ' marks the value from one accepted strobe earlier and '' the value from two earlier. Both are zero right after a ratio write.
- R9: After K accepted strobes since a ratio write, the sum of (`n_out` − INT) differs from K·FRAC/MOD by at most 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 1 | Write target: 0 = ratio (INT/FRAC), 1 = modulus |
| wr_data | input | 21 | Write data |
| step | input | 1 | Reference-rate update strobe |
| n_out | output | 10 | Registered division value for the current divider cycle |

## Verification
A wrong residue or carry inside the cascade shows up on `n_out` in the first strobe that depends on it. The bench's reference model predicts every output value, so such a fault is flagged within one clock. A modulus armed too early or too late changes the wrap points, and the output diverges within a few strobes of the misplaced write. A drift in the long-run ratio is caught by the running-sum check after a full modulus period.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;

  localparam int STAGES = 3;

  typedef enum logic {
    SEL_RATIO = 1'b0,
    SEL_MOD   = 1'b1
  } wsel_e;

  // third-order noise-shaped correction from current and delayed carries
  function automatic logic signed [3:0] mash_offset(
    input logic c1, input logic c2, input logic c2_d,
    input logic c3, input logic c3_d, input logic c3_dd);
    int v;
    v = int'(c1) + int'(c2) - int'(c2_d)
      + int'(c3) - 2 * int'(c3_d) + int'(c3_dd);
    return 4'(v);
  endfunction

endpackage

// File: rtl/fracn_regs.sv
`timescale 1ns/1ps
module fracn_regs #(
  parameter int          INT_W   = 9,
  parameter int          FRAC_W  = 12,
  parameter int unsigned RST_MOD = 4095
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ratio_wr,
  input  logic                     mod_wr,
  input  logic [INT_W+FRAC_W-1:0]  wdata,
  output logic [INT_W-1:0]         int_q,
  output logic [FRAC_W-1:0]        frac_q,
  output logic [FRAC_W-1:0]        mod_pend,
  output logic [FRAC_W-1:0]        mod_act
);
  localparam int DW = INT_W + FRAC_W;
  localparam logic [FRAC_W-1:0] MOD_INIT = FRAC_W'(RST_MOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q    <= '0;
      frac_q   <= '0;
      mod_pend <= MOD_INIT;
      mod_act  <= MOD_INIT;
    end else begin
      if (mod_wr) mod_pend <= wdata[FRAC_W-1:0];
      if (ratio_wr) begin
        int_q   <= wdata[DW-1:FRAC_W];
        frac_q  <= wdata[FRAC_W-1:0];
        mod_act <= mod_pend;
      end
    end
  end
endmodule

// File: rtl/fracn_acc_stage.sv
`timescale 1ns/1ps
module fracn_acc_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [W-1:0] addend,
  input  logic [W-1:0] modulus,
  output logic [W-1:0] res_q,
  output logic [W-1:0] res_nx,
  output logic         carry
);
  logic [W:0] sum;

  always_comb begin
    sum    = {1'b0, res_q} + {1'b0, addend};
    carry  = (sum >= {1'b0, modulus});
    res_nx = carry ? W'(sum - {1'b0, modulus}) : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   res_q <= '0;
    else if (clr) res_q <= '0;
    else if (adv) res_q <= res_nx;
  end
endmodule

// File: rtl/fracn_noise_comb.sv
`timescale 1ns/1ps
module fracn_noise_comb
  import fracn_pkg::*;
#(
  parameter int INT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [STAGES-1:0] carry,
  input  logic [INT_W-1:0]  int_val,
  output logic [INT_W:0]    n_q
);
  localparam int NW = INT_W + 1;

  logic              c2_d, c3_d, c3_dd;
  logic signed [3:0] offset;
  logic [NW-1:0]     n_sum;

  assign offset = mash_offset(carry[0], carry[1], c2_d, carry[2], c3_d, c3_dd);
  assign n_sum  = {1'b0, int_val} + {{(NW-4){offset[3]}}, offset};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
      n_q   <= '0;
    end else if (clr) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (adv) begin
      c2_d  <= carry[1];
      c3_d  <= carry[2];
      c3_dd <= c3_d;
      n_q   <= n_sum;
    end
  end
endmodule

// File: rtl/fracn_divctl.sv
`timescale 1ns/1ps
module fracn_divctl
  import fracn_pkg::*;
#(
  parameter int          INT_W   = 9,
  parameter int          FRAC_W  = 12,
  parameter int unsigned RST_MOD = 4095
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    wr_sel,
  input  logic [INT_W+FRAC_W-1:0] wr_data,
  input  logic                    step,
  output logic [INT_W:0]          n_out
);
  logic ratio_wr, mod_wr, step_go;
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q, mod_pend, mod_act;
  logic [STAGES-1:0][FRAC_W-1:0] res_q, res_nx;
  logic [STAGES-1:0] carry;

  assign ratio_wr = wr_en && (wsel_e'(wr_sel) == SEL_RATIO);
  assign mod_wr   = wr_en && (wsel_e'(wr_sel) == SEL_MOD);
  assign step_go  = step && !wr_en;

  fracn_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .RST_MOD(RST_MOD)) u_regs (
    .clk(clk), .rst_n(rst_n), .ratio_wr(ratio_wr), .mod_wr(mod_wr),
    .wdata(wr_data), .int_q(int_q), .frac_q(frac_q),
    .mod_pend(mod_pend), .mod_act(mod_act)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [FRAC_W-1:0] addend;
    if (k == 0) begin : g_head
      assign addend = frac_q;
    end else begin : g_tail
      assign addend = res_nx[k-1];
    end
    fracn_acc_stage #(.W(FRAC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(ratio_wr), .adv(step_go),
      .addend(addend), .modulus(mod_act),
      .res_q(res_q[k]), .res_nx(res_nx[k]), .carry(carry[k])
    );
  end

  fracn_noise_comb #(.INT_W(INT_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(ratio_wr), .adv(step_go),
    .carry(carry), .int_val(int_q), .n_q(n_out)
  );
endmodule

// File: rtl/fracn_divctl_chk.sv
`timescale 1ns/1ps
module fracn_divctl_chk
  import fracn_pkg::*;
#(
  parameter int INT_W  = 9,
  parameter int FRAC_W = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          step_go,
  input logic                          ratio_wr,
  input logic                          mod_wr,
  input logic [INT_W-1:0]              int_q,
  input logic [FRAC_W-1:0]             frac_q,
  input logic [FRAC_W-1:0]             mod_pend,
  input logic [FRAC_W-1:0]             mod_act,
  input logic [STAGES-1:0][FRAC_W-1:0] res_q,
  input logic [STAGES-1:0][FRAC_W-1:0] res_nx,
  input logic [INT_W:0]                n_out
);
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> (res_q == '0));

  assert_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mod_wr |=> $stable(mod_act));

  assert_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_wr |=> (mod_act == $past(mod_pend)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_go |=> $stable(n_out));

  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && int_q >= INT_W'(3)) |=>
      ((int'(n_out) >= int'(int_q) - 3) && (int'(n_out) <= int'(int_q) + 4)));

  assert_frac_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && frac_q == '0) |=> (n_out == {1'b0, int_q}));

  for (genvar k = 0; k < STAGES; k++) begin : g_bound
    assert_residue_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_go && frac_q < mod_act) |-> (res_nx[k] < mod_act));
  end
endmodule

bind fracn_divctl fracn_divctl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_go(step_go), .ratio_wr(ratio_wr),
  .mod_wr(mod_wr), .int_q(int_q), .frac_q(frac_q), .mod_pend(mod_pend),
  .mod_act(mod_act), .res_q(res_q), .res_nx(res_nx), .n_out(n_out)
);

// File: tb/fracn_divctl_test.sv
`timescale 1ns/1ps
module fracn_divctl_test;
  localparam int IW = 9;
  localparam int FW = 12;
  localparam int DW = IW + FW;
  localparam int RMOD = 4095;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic step = 1'b0;
  logic [IW:0] n_out;

  int tests = 0;
  int fails = 0;
  string tag_now = "R1";
  bit cmp_on = 1'b0;

  // reference model state
  int m_int, m_frac, m_mod, m_pend, a1, a2, a3, n_exp;
  int c2h[$];
  int c3h[$];

  // observed statistics since last ratio write
  longint obs_sum;
  longint obs_cnt;
  int cur_int, cur_frac, cur_mod;

  always #10 clk = ~clk;

  fracn_divctl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .step(step), .n_out(n_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_int = 0; m_frac = 0; m_mod = RMOD; m_pend = RMOD;
      a1 = 0; a2 = 0; a3 = 0; n_exp = 0;
      c2h = '{0}; c3h = '{0, 0};
    end else if (wr_en) begin
      if (wr_sel == 1'b0) begin
        m_int  = int'(wr_data) >> FW;
        m_frac = int'(wr_data) % (1 << FW);
        m_mod  = m_pend;
        a1 = 0; a2 = 0; a3 = 0;
        c2h = '{0}; c3h = '{0, 0};
      end else begin
        m_pend = int'(wr_data) % (1 << FW);
      end
    end else if (step) begin
      int c1, c2, c3;
      a1 += m_frac; c1 = (a1 >= m_mod) ? 1 : 0; a1 -= c1 * m_mod;
      a2 += a1;     c2 = (a2 >= m_mod) ? 1 : 0; a2 -= c2 * m_mod;
      a3 += a2;     c3 = (a3 >= m_mod) ? 1 : 0; a3 -= c3 * m_mod;
      n_exp = m_int + c1 + c2 - c2h[0] + c3 - 2 * c3h[0] + c3h[1];
      c2h.push_front(c2); void'(c2h.pop_back());
      c3h.push_front(c3); void'(c3h.pop_back());
    end
  end

  // per-clock comparison against the model (R8 sequence, tagged by phase)
  always @(negedge clk) begin
    if (rst_n && cmp_on)
      check(int'(n_out) == n_exp, tag_now, int'(n_out), n_exp);
  end

  task automatic ratio_write(input int iv, input int fv, input bit with_step);
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = DW'((iv << FW) | fv); step = with_step;
    @(negedge clk);
    wr_en = 1'b0; step = 1'b0;
    cur_int = iv; cur_frac = fv; obs_sum = 0; obs_cnt = 0;
  endtask

  task automatic mod_write(input int mv, input bit with_step);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = DW'(mv); step = with_step;
    @(negedge clk);
    wr_en = 1'b0; step = 1'b0;
  endtask

  task automatic run_steps(input int k, input bit gap);
    for (int i = 0; i < k; i++) begin
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      obs_sum += longint'(int'(n_out) - cur_int);
      obs_cnt++;
      if (cur_int >= 3)
        check((int'(n_out) >= cur_int - 3) && (int'(n_out) <= cur_int + 4),
              "R6", int'(n_out), cur_int);
      if (gap) @(negedge clk);
    end
  endtask

  task automatic check_average(input string req);
    longint err;
    err = longint'(cur_mod) * obs_sum - obs_cnt * longint'(cur_frac);
    if (err < 0) err = -err;
    check(err <= 3 * longint'(cur_mod), req, int'(err), 3 * cur_mod);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    check(n_out == '0, "R1", int'(n_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(n_out == '0, "R1", int'(n_out), 0);
    cmp_on = 1'b1;
    tag_now = "R1";
    cur_int = 0; cur_frac = 0; cur_mod = RMOD;
    run_steps(5, 1'b0);
    check(n_out == '0, "R1", int'(n_out), 0);

    // R7: integer-only ratio
    tag_now = "R7";
    ratio_write(100, 0, 1'b0);
    run_steps(20, 1'b0);
    check(int'(n_out) == 100, "R7", int'(n_out), 100);

    // R2: new ratio does not move the output before the next strobe
    tag_now = "R2";
    held = int'(n_out);
    ratio_write(200, 1234, 1'b0);
    check(int'(n_out) == held, "R2", int'(n_out), held);
    @(negedge clk);
    check(int'(n_out) == held, "R2", int'(n_out), held);

    // R8: fractional sequence with reset modulus
    tag_now = "R8";
    cur_mod = RMOD;
    run_steps(300, 1'b0);

    // R3: pending modulus must not alter the running sequence
    tag_now = "R3";
    mod_write(1000, 1'b0);
    run_steps(200, 1'b0);

    // R4: ratio write arms the pending modulus
    tag_now = "R4";
    ratio_write(200, 777, 1'b0);
    cur_mod = 1000;
    run_steps(2000, 1'b0);
    check_average("R9");

    // R5: sparse strobes and strobes colliding with writes
    tag_now = "R5";
    run_steps(40, 1'b1);
    held = int'(n_out);
    mod_write(7, 1'b1);
    check(int'(n_out) == held, "R5", int'(n_out), held);
    ratio_write(3, 3, 1'b1);
    check(int'(n_out) == held, "R5", int'(n_out), held);
    cur_mod = 7;

    // R6/R9: small odd modulus with low INT
    tag_now = "R6";
    run_steps(700, 1'b0);
    check_average("R9");

    // R8: FRAC = MOD-1 with a new modulus
    tag_now = "R8";
    mod_write(5, 1'b0);
    ratio_write(10, 4, 1'b0);
    cur_mod = 5;
    run_steps(500, 1'b0);
    check_average("R9");

    cmp_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule